// File: doc/BRIEF.md
# ECC Fault Reporting and Injection Unit

This unit collects the per-read error-correction results of a memory array read path and turns them into sticky status flags, a capture record of the failing location, and interrupt requests. A command sequencer supplies a level flag that says the last command has finished. A byte-wide register port lets software set the configuration, enable the interrupts, read and clear the status, and read the captured address and syndrome.

Software can inject faults. While an injection bit is set, every array read raises the matching status flag, so an interrupt handler can be tested without a real error. Injected faults never write the capture record. A separate suppress bit stops real single-bit faults from being reported, but it does not stop injected ones.

Top module: `ecc_fault_report`

## Requirements
- R1: The configuration register sits at offset 0. Bit 7 is the command-done interrupt enable, bit 4 suppresses real single faults, bit 1 injects double faults and bit 0 injects single faults. All other bits read 0 and ignore writes. The register resets to 0.
- R2: `irq_cmd` is high in the same cycle whenever `cmd_done` is high and configuration bit 7 is 1. Status bit 7 at offset 2 shows `cmd_done` live.
- R3: When configuration bit 4 is 1, a real single fault sets no flag, raises no single-fault interrupt and is not captured.
- R4: When configuration bit 1 is 1, every read (`rd_valid`) sets the double-fault flag, status bit 1. `irq_dbl` is high only while that flag and enable bit 1 are both set.
- R5: When configuration bit 0 is 1, every read sets the single-fault flag, status bit 0. `irq_sgl` is high only while that flag and enable bit 0 are both set.
- R6: A read that carries no real fault of a given type leaves the capture record unchanged, whatever the injection bits are.
- R7: An injection bit stays set across any number of reads. Only a write of 0 to that bit clears it.
- R8: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 has no effect. A flag set in the same cycle as the clear stays set.
- R9: A read that reports a single and a double fault at once is captured as a double fault.
- R10: An injected single fault is reported even when configuration bit 4 is 1.
- R11: The capture record latches the address and syndrome of the first real fault while it is empty. It holds them until software clears the status flag of the captured type. Status bit 2 means the record holds a single fault and bit 3 means it holds a double fault. Offsets 3 and 4 read address bits 7:0 and 15:8, and offset 5 reads the syndrome.
- R12: The error-enable register sits at offset 1. Bit 0 enables the single-fault interrupt and bit 1 enables the double-fault interrupt. Both reset to 0 and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel` (combinational) |
| rd_valid | input | 1 | An array read completes this cycle |
| rd_sbe | input | 1 | Real single-bit fault on this read |
| rd_dbe | input | 1 | Real double-bit fault on this read |
| rd_addr | input | ADDR_W | Address of the read |
| rd_syn | input | SYN_W | Syndrome of the read |
| cmd_done | input | 1 | Command-complete level from the sequencer |
| irq_cmd | output | 1 | Command-complete interrupt |
| irq_sgl | output | 1 | Single-fault interrupt |
| irq_dbl | output | 1 | Double-fault interrupt |

## Verification
Register writes, flag updates and capture take effect on the clock edge that samples the stimulus. They are visible on `reg_rdata`, `irq_sgl` and `irq_dbl` one cycle later. `irq_cmd` and status bit 7 follow `cmd_done` within the same cycle. The bench updates its model at each rising edge with the inputs that edge sampled. At the following falling edge it reads back every register and all three interrupt lines. That timing fits the one-cycle latency of the flag and capture results, and `cmd_done` is held steady while it is compared.

// File: rtl/ecc_flt_pkg.sv
package ecc_flt_pkg;

    typedef enum logic [2:0] {
        REG_CFG     = 3'd0,
        REG_ERREN   = 3'd1,
        REG_STAT    = 3'd2,
        REG_CAP_LO  = 3'd3,
        REG_CAP_HI  = 3'd4,
        REG_CAP_SYN = 3'd5
    } reg_sel_e;

    localparam int CFG_FSGL_BIT = 0;
    localparam int CFG_FDBL_BIT = 1;
    localparam int CFG_IGN_BIT  = 4;
    localparam int CFG_CIE_BIT  = 7;
    localparam logic [7:0] CFG_WR_MASK = 8'h93;

    localparam int KIND_SGL  = 0;
    localparam int KIND_DBL  = 1;
    localparam int NUM_KINDS = 2;

    localparam int STAT_CAP_SGL_BIT = 2;
    localparam int STAT_CAP_DBL_BIT = 3;
    localparam int STAT_CMD_BIT     = 7;

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_SGL  = 2'd1,
        CAP_DBL  = 2'd2
    } cap_kind_e;

endpackage

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
    import ecc_flt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] sel,
    input  logic [7:0] wdata,
    output logic [7:0] cfg_o,
    output logic [NUM_KINDS-1:0] en_o
);

    typedef struct packed {
        logic [7:0]           cfg;
        logic [NUM_KINDS-1:0] en;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && sel == REG_CFG) begin
            st_d.cfg = wdata & CFG_WR_MASK;
        end
        if (wr_en && sel == REG_ERREN) begin
            st_d.en = wdata[NUM_KINDS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
    assign en_o  = st_q.en;

    AST_FSGL_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.cfg[CFG_FSGL_BIT]) |-> $past(wr_en && sel == REG_CFG && !wdata[CFG_FSGL_BIT])); // R7
    AST_FDBL_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.cfg[CFG_FDBL_BIT]) |-> $past(wr_en && sel == REG_CFG && !wdata[CFG_FDBL_BIT])); // R7

endmodule

// File: rtl/ecc_fault_flag.sv
module ecc_fault_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic real_hit,
    input  logic force_hit,
    input  logic clr,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flag = 1'b0;
        end
        if (real_hit || force_hit) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    AST_FORCE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        force_hit |=> st_q.flag); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !real_hit && !force_hit) |=> !st_q.flag); // R8
    AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(clr)); // R8

endmodule

// File: rtl/ecc_capture.sv
module ecc_capture
    import ecc_flt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              sbe,
    input  logic              dbe,
    input  logic              ignore_sgl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SYN_W-1:0]  syn,
    input  logic              clr_sgl,
    input  logic              clr_dbl,
    output cap_kind_e         kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SYN_W-1:0]  syn_o
);

    typedef struct packed {
        cap_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [SYN_W-1:0]  syn;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       release_c;
    logic       real_s, real_d;
    cap_kind_e  kind_eff;

    always_comb begin
        release_c = (st_q.kind == CAP_SGL && clr_sgl) ||
                    (st_q.kind == CAP_DBL && clr_dbl);
        real_d    = rd_valid && dbe;
        real_s    = rd_valid && sbe && !ignore_sgl;
        kind_eff  = release_c ? CAP_NONE : st_q.kind;
        st_d      = st_q;
        st_d.kind = kind_eff;
        if (kind_eff == CAP_NONE && (real_d || real_s)) begin
            st_d.kind = real_d ? CAP_DBL : CAP_SGL;
            st_d.addr = addr;
            st_d.syn  = syn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kind_o = st_q.kind;
    assign addr_o = st_q.addr;
    assign syn_o  = st_q.syn;

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind != CAP_NONE && !clr_sgl && !clr_dbl)
        |=> ($stable(st_q.addr) && $stable(st_q.syn) && $stable(st_q.kind))); // R11
    AST_CAP_DBL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == CAP_NONE && rd_valid && sbe && dbe) |=> st_q.kind == CAP_DBL); // R9
    AST_CAP_NO_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == CAP_NONE && !(rd_valid && (sbe || dbe))) |=> st_q.kind == CAP_NONE); // R6

endmodule

// File: rtl/ecc_fault_report.sv
module ecc_fault_report
    import ecc_flt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              rd_valid,
    input  logic              rd_sbe,
    input  logic              rd_dbe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SYN_W-1:0]  rd_syn,
    input  logic              cmd_done,
    output logic              irq_cmd,
    output logic              irq_sgl,
    output logic              irq_dbl
);

    localparam int CAP_BUS_W = 16;
    localparam int SYN_BUS_W = 8;

    logic [7:0]           cfg;
    logic [NUM_KINDS-1:0] en;
    logic [NUM_KINDS-1:0] real_hit, force_hit, clr_hit, flag, irq_flt;
    logic                 stat_wr;
    cap_kind_e            cap_kind;
    logic [ADDR_W-1:0]    cap_addr;
    logic [SYN_W-1:0]     cap_syn;
    logic [CAP_BUS_W-1:0] cap_addr_ext;
    logic [SYN_BUS_W-1:0] cap_syn_ext;

    ecc_cfg_regs i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .cfg_o (cfg),
        .en_o  (en)
    );

    assign stat_wr              = reg_wr && reg_sel == REG_STAT;
    assign real_hit[KIND_SGL]   = rd_valid && rd_sbe && !cfg[CFG_IGN_BIT];
    assign real_hit[KIND_DBL]   = rd_valid && rd_dbe;
    assign force_hit[KIND_SGL]  = rd_valid && cfg[CFG_FSGL_BIT];
    assign force_hit[KIND_DBL]  = rd_valid && cfg[CFG_FDBL_BIT];

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_flag
        assign clr_hit[k] = stat_wr && reg_wdata[k];
        ecc_fault_flag i_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .real_hit  (real_hit[k]),
            .force_hit (force_hit[k]),
            .clr       (clr_hit[k]),
            .flag_o    (flag[k])
        );
        assign irq_flt[k] = flag[k] && en[k];
    end

    ecc_capture #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) i_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_valid   (rd_valid),
        .sbe        (rd_sbe),
        .dbe        (rd_dbe),
        .ignore_sgl (cfg[CFG_IGN_BIT]),
        .addr       (rd_addr),
        .syn        (rd_syn),
        .clr_sgl    (clr_hit[KIND_SGL]),
        .clr_dbl    (clr_hit[KIND_DBL]),
        .kind_o     (cap_kind),
        .addr_o     (cap_addr),
        .syn_o      (cap_syn)
    );

    assign cap_addr_ext = CAP_BUS_W'(cap_addr);
    assign cap_syn_ext  = SYN_BUS_W'(cap_syn);

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            REG_CFG:     reg_rdata = cfg;
            REG_ERREN:   reg_rdata[NUM_KINDS-1:0] = en;
            REG_STAT: begin
                reg_rdata[NUM_KINDS-1:0]     = flag;
                reg_rdata[STAT_CAP_SGL_BIT]  = cap_kind == CAP_SGL;
                reg_rdata[STAT_CAP_DBL_BIT]  = cap_kind == CAP_DBL;
                reg_rdata[STAT_CMD_BIT]      = cmd_done;
            end
            REG_CAP_LO:  reg_rdata = cap_addr_ext[7:0];
            REG_CAP_HI:  reg_rdata = cap_addr_ext[15:8];
            REG_CAP_SYN: reg_rdata = cap_syn_ext;
            default:     reg_rdata = '0;
        endcase
    end

    assign irq_cmd = cmd_done && cfg[CFG_CIE_BIT];
    assign irq_sgl = irq_flt[KIND_SGL];
    assign irq_dbl = irq_flt[KIND_DBL];

    AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == REG_CFG) |-> ((reg_rdata & ~CFG_WR_MASK) == 8'h00)); // R1
    AST_IGNORE_SGL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[KIND_SGL]) |-> $past(rd_valid && ((rd_sbe && !cfg[CFG_IGN_BIT]) || cfg[CFG_FSGL_BIT]))); // R3
    AST_FDBL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cfg[CFG_FDBL_BIT]) |=> flag[KIND_DBL]); // R4

endmodule

// File: tb/test_ecc_fault_report.sv
module test_ecc_fault_report;

    localparam int CLK_PERIOD = 20;
    localparam int ADDR_W = 16;
    localparam int SYN_W  = 8;
    localparam int N_RAND = 3000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_sel = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              rd_valid = 1'b0, rd_sbe = 1'b0, rd_dbe = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [SYN_W-1:0]  rd_syn = '0;
    logic              cmd_done = 1'b0;
    logic              irq_cmd, irq_sgl, irq_dbl;

    int n_checks = 0;
    int n_fails  = 0;

    // model state
    logic [7:0]  m_cfg = '0;
    logic [1:0]  m_en = '0;
    logic        m_sf = 0, m_df = 0;
    int          m_kind = 0; // 0 none, 1 single, 2 double
    logic [15:0] m_addr = '0;
    logic [7:0]  m_syn = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_fault_report #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) i_ecc_fault_report (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_valid(rd_valid),
        .rd_sbe(rd_sbe), .rd_dbe(rd_dbe), .rd_addr(rd_addr), .rd_syn(rd_syn),
        .cmd_done(cmd_done), .irq_cmd(irq_cmd), .irq_sgl(irq_sgl), .irq_dbl(irq_dbl)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        exp_stat = {cmd_done, 3'b000, m_kind == 2, m_kind == 1, m_df, m_sf};
    endfunction

    // advance model by one edge with the currently driven inputs
    task automatic model_edge();
        logic ign, sset, dset, sclr, dclr, rel, rs, rdd;
        int keff;
        ign  = m_cfg[4];
        sset = rd_valid && ((rd_sbe && !ign) || m_cfg[0]);
        dset = rd_valid && (rd_dbe || m_cfg[1]);
        sclr = reg_wr && reg_sel == 3'd2 && reg_wdata[0];
        dclr = reg_wr && reg_sel == 3'd2 && reg_wdata[1];
        rel  = (m_kind == 1 && sclr) || (m_kind == 2 && dclr);
        keff = rel ? 0 : m_kind;
        rdd  = rd_valid && rd_dbe;
        rs   = rd_valid && rd_sbe && !ign;
        if (keff == 0 && (rdd || rs)) begin
            m_kind = rdd ? 2 : 1;
            m_addr = 16'(rd_addr);
            m_syn  = 8'(rd_syn);
        end else begin
            m_kind = keff;
        end
        m_sf = sset || (m_sf && !sclr);
        m_df = dset || (m_df && !dclr);
        if (reg_wr && reg_sel == 3'd0) m_cfg = reg_wdata & 8'h93;
        if (reg_wr && reg_sel == 3'd1) m_en = reg_wdata[1:0];
    endtask

    // called in the low phase: reads every register and the interrupt lines
    task automatic verify();
        reg_wr = 1'b0;
        rd_valid = 1'b0;
        reg_sel = 3'd0; #1; check("R1 cfg", reg_rdata, m_cfg);
        reg_sel = 3'd1; #1; check("R12 enable", reg_rdata, {6'b0, m_en});
        reg_sel = 3'd2; #1; check("R8 status", reg_rdata, exp_stat());
        reg_sel = 3'd3; #1; check("R11 cap lo", reg_rdata, m_addr[7:0]);
        reg_sel = 3'd4; #1; check("R11 cap hi", reg_rdata, m_addr[15:8]);
        reg_sel = 3'd5; #1; check("R11 cap syn", reg_rdata, m_syn);
        check("R2 irq_cmd", irq_cmd, cmd_done && m_cfg[7]);
        check("R5 irq_sgl", irq_sgl, m_sf && m_en[0]);
        check("R4 irq_dbl", irq_dbl, m_df && m_en[1]);
    endtask

    task automatic cycle(input logic wr, input logic [2:0] sel, input logic [7:0] wd,
                         input logic rv, input logic s, input logic d,
                         input logic [15:0] a, input logic [7:0] sy);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        rd_valid = rv; rd_sbe = s; rd_dbe = d; rd_addr = a; rd_syn = sy;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        verify();
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [7:0] wd);
        cycle(1'b1, sel, wd, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
    endtask

    task automatic rd(input logic s, input logic d, input logic [15:0] a, input logic [7:0] sy);
        cycle(1'b0, 3'd7, 8'h00, 1'b1, s, d, a, sy);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk); @(negedge clk);
        verify(); // reset values, R1 R12
        rst_n = 1'b1;
        @(negedge clk);
        verify();

        // R1: reserved bits stay 0
        wreg(3'd0, 8'hFF);
        check("R1 write mask", m_cfg, 8'h93);
        wreg(3'd1, 8'hFF); // R12
        // R2: command-done interrupt follows enable
        cmd_done = 1'b1; #1; check("R2 irq_cmd on", irq_cmd, 1);
        wreg(3'd0, 8'h00);
        check("R2 irq_cmd masked", irq_cmd, 0);
        cmd_done = 1'b0;

        // R3: ignored real single fault
        wreg(3'd0, 8'h10);
        rd(1'b1, 1'b0, 16'h1234, 8'h55);
        reg_sel = 3'd2; #1; check("R3 ignored single", reg_rdata[2:0], 0);
        check("R3 no irq", irq_sgl, 0);

        // R4 R6 R7: forced double on clean reads
        wreg(3'd0, 8'h02);
        rd(1'b0, 1'b0, 16'hAAAA, 8'h11);
        rd(1'b0, 1'b0, 16'hBBBB, 8'h22);
        reg_sel = 3'd2; #1; check("R4 forced dbl flag", reg_rdata[3:0], 4'b0010);
        check("R4 irq_dbl", irq_dbl, 1);
        reg_sel = 3'd0; #1; check("R7 force persists", reg_rdata, 8'h02);
        reg_sel = 3'd3; #1; check("R6 no capture", reg_rdata, 8'h00);
        wreg(3'd2, 8'h00); // R8 write 0 no effect
        wreg(3'd0, 8'h00); // R7 clear force
        wreg(3'd2, 8'h02);
        reg_sel = 3'd2; #1; check("R8 w1c dbl", reg_rdata[1], 0);

        // R10: forced single despite ignore
        wreg(3'd0, 8'h11);
        rd(1'b1, 1'b0, 16'h4321, 8'h33);
        reg_sel = 3'd2; #1; check("R10 forced single", reg_rdata[3:0], 4'b0001);
        wreg(3'd0, 8'h00);
        wreg(3'd2, 8'h03);

        // R9 R11: both faults -> double captured, then held
        rd(1'b1, 1'b1, 16'hC0DE, 8'h7E);
        reg_sel = 3'd2; #1; check("R9 dbl captured", reg_rdata[3:2], 2'b10);
        rd(1'b1, 1'b0, 16'h0F0F, 8'h01);
        reg_sel = 3'd4; #1; check("R11 held addr", reg_rdata, 8'hC0);
        wreg(3'd2, 8'h01); // clearing single does not release double capture
        reg_sel = 3'd2; #1; check("R11 still held", reg_rdata[3:2], 2'b10);
        wreg(3'd2, 8'h02);
        reg_sel = 3'd2; #1; check("R11 released", reg_rdata[3:2], 2'b00);
        // R8: set wins over clear in the same cycle
        wreg(3'd0, 8'h01);
        cycle(1'b1, 3'd2, 8'h01, 1'b1, 1'b0, 1'b0, 16'h0, 8'h0);
        reg_sel = 3'd2; #1; check("R8 set wins", reg_rdata[0], 1);
        wreg(3'd0, 8'h00);

        for (int i = 0; i < N_RAND; i++) begin
            logic        w;
            logic [2:0]  sel;
            logic [7:0]  wd;
            w   = ($urandom % 4) == 0;
            sel = 3'($urandom % 7);
            wd  = 8'($urandom);
            if (sel == 3'd0 && ($urandom % 2) == 0) wd[1:0] = 2'b00;
            cmd_done = ($urandom % 3) == 0;
            cycle(w, sel, wd, ($urandom % 2) == 0, ($urandom % 4) == 0,
                  ($urandom % 6) == 0, 16'($urandom), 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule